// File: doc/BRIEF.md
# Embedded Sync Video Decoder

This block sits on a 16-bit YCbCr 4:2:2 video input whose line and frame timing is carried in-band as four-word timing codes, not on separate wires. It watches the word stream for a code, decodes the status word that ends the code, and rebuilds separate horizontal sync, vertical sync and data-enable outputs. These outputs are aligned with a delayed copy of the pixel word, so a downstream block that expects discrete sync can take the stream directly.

The decoder also measures the active pixels in each line and the active lines in each frame. It raises a lock flag once one frame repeats the shape of the frame before it. It flags protocol violations: reserved byte values inside active video, and status words that are not one of the four legal codes.

Top module: `vid_sync_dec`

## Requirements
- R1: While rst_ni is low, every output (pix_o, de_o, hs_o, vs_o, lock_o, err_o) is 0.
- R2: pix_o repeats data_i with a fixed latency: the word sampled at clock edge k appears on pix_o after edge k+4.
- R3: A timing code is recognised only when four consecutive words are all-ones (0xFFFF), 0x0000, 0x0000, and then a status word whose two bytes are equal. In the status byte, bit 4 is the end-of-line flag and bit 5 is the blanking flag. The legal status bytes are 0x80 (active start), 0x9D (active end), 0xAB (blanking start) and 0xB6 (blanking end). A sequence that differs in any preamble bit is treated as ordinary data.
- R4: de_o is high exactly for the words that lie after an active start code and before the next end code. Filler (0x8010), code words and every word in blanking lines leave de_o low.
- R5: hs_o is high for one clock for each end-of-line code, active or blanking, in the cycle in which the code's 0xFFFF word is on pix_o.
- R6: On each start-of-line code, vs_o takes the code's blanking flag. The change occurs in the cycle in which that code's 0xFFFF word is on pix_o, so vs_o rises on the first blanking line after active lines and falls on the first active line.
- R7: A word with de_o high that holds a byte of 0x00 or 0xFF raises err_o in the same cycle.
- R8: A preamble followed by an illegal status word, or by a status word with unequal bytes, raises err_o for one clock in the cycle its 0xFFFF word is on pix_o. It leaves de_o, hs_o and vs_o unchanged.
- R9: At a frame end, which is the start of the first blanking line after active lines, lock_o is set if the frame's lines all had one width and that width and the line count equal those of the previous frame. The previous frame must also have been uniform. lock_o changes only at a frame end.
- R10: At a frame end that fails any condition of R9, lock_o is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | 4:2:2 word stream with embedded timing codes |
| pix_o | output | DATA_W | Delayed pixel word, aligned with the sync outputs |
| de_o | output | 1 | Active pixel enable |
| hs_o | output | 1 | One-clock pulse per end-of-line code |
| vs_o | output | 1 | High during vertical blanking |
| lock_o | output | 1 | Two consecutive frames of matching shape |
| err_o | output | 1 | Reserved byte in active video, or illegal status word |

## Verification
The bench drives frames that keep their shape, then change width, then change line count. It checks that lock_o drops at the first frame that differs and returns only one frame later. A decoder that compared against a fixed format, or that updated the lock outside frame ends, would show the wrong lock_o. A frame with one short line, followed by a well-formed frame, shows whether a non-uniform frame is refused as a reference. A near-miss preamble, a status word with unequal bytes and a 0x00FF pixel check the error path: a decoder that matched on one byte lane, or that acted on a bad code, would change vs_o or de_o where it must not. Each word's de_o, hs_o and vs_o are compared at the exact output cycle, so an off-by-one in the code look-ahead would cover a code word or drop the last pixel.

// File: rtl/vid_sync_pkg.sv
package vid_sync_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CODE_LEN = 4;
  localparam int unsigned H_POS    = 4;
  localparam int unsigned V_POS    = 5;

  localparam logic [BYTE_W-1:0] STS_SOL_ACT = 8'h80;
  localparam logic [BYTE_W-1:0] STS_EOL_ACT = 8'h9D;
  localparam logic [BYTE_W-1:0] STS_SOL_BLK = 8'hAB;
  localparam logic [BYTE_W-1:0] STS_EOL_BLK = 8'hB6;

  typedef struct packed {
    logic hit;    // preamble complete
    logic valid;  // status word legal
    logic eol;
    logic blank;
  } code_t;

  function automatic logic status_legal(input logic [BYTE_W-1:0] b);
    return (b == STS_SOL_ACT) || (b == STS_EOL_ACT) ||
           (b == STS_SOL_BLK) || (b == STS_EOL_BLK);
  endfunction
endpackage

// File: rtl/vid_trs_detect.sv
module vid_trs_detect
  import vid_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] tap_o,
  output code_t             code_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;

  // dly_q[0] newest, dly_q[CODE_LEN-1] oldest
  logic [CODE_LEN-1:0][DATA_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= {dly_q[CODE_LEN-2:0], data_i};
  end

  logic pre_ok;
  always_comb begin
    pre_ok = (dly_q[CODE_LEN-1] == '1);
    for (int i = 1; i < CODE_LEN - 1; i++) begin
      if (dly_q[i] != '0) pre_ok = 1'b0;
    end
  end

  logic [BYTE_W-1:0] sts_b;
  logic [LANES-1:0]  lane_eq;
  assign sts_b = dly_q[0][BYTE_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (dly_q[0][l*BYTE_W +: BYTE_W] == sts_b);
  end

  assign code_o.hit   = pre_ok;
  assign code_o.valid = (&lane_eq) && status_legal(sts_b);
  assign code_o.eol   = sts_b[H_POS];
  assign code_o.blank = sts_b[V_POS];
  assign tap_o        = dly_q[CODE_LEN-1];
endmodule

// File: rtl/vid_line_track.sv
module vid_line_track
  import vid_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tap_i,
  input  code_t             code_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              err_o,
  output logic              pix_stb_o,
  output logic              eol_stb_o,
  output logic              eof_stb_o
);
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned SKIP_W = $clog2(CODE_LEN);

  logic [SKIP_W-1:0] skip_q;
  logic              act_q;
  logic [LANES-1:0]  lane_rsv;

  for (genvar l = 0; l < LANES; l++) begin : g_rsv
    assign lane_rsv[l] = (tap_i[l*BYTE_W +: BYTE_W] == '0) ||
                         (tap_i[l*BYTE_W +: BYTE_W] == '1);
  end

  logic hit_ok, hit_bad, sol, eol, pixel, rsv_err, eof;
  always_comb begin
    hit_ok  = code_i.hit && code_i.valid;
    hit_bad = code_i.hit && !code_i.valid;
    sol     = hit_ok && !code_i.eol;
    eol     = hit_ok && code_i.eol;
    // code words after the first are masked by skip_q
    pixel   = act_q && (skip_q == '0) && !hit_ok;
    rsv_err = pixel && (|lane_rsv);
    eof     = sol && code_i.blank && !vs_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o  <= '0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      err_o  <= 1'b0;
      skip_q <= '0;
      act_q  <= 1'b0;
    end else begin
      pix_o <= tap_i;
      de_o  <= pixel;
      hs_o  <= eol;
      err_o <= rsv_err || hit_bad;
      if (sol) vs_o <= code_i.blank;
      if (hit_ok)             skip_q <= SKIP_W'(CODE_LEN - 1);
      else if (skip_q != '0)  skip_q <= skip_q - 1'b1;
      if (sol)      act_q <= !code_i.blank;
      else if (eol) act_q <= 1'b0;
    end
  end

  assign pix_stb_o = pixel;
  assign eol_stb_o = eol && act_q;
  assign eof_stb_o = eof;
endmodule

// File: rtl/vid_frame_mon.sv
module vid_frame_mon #(
  parameter int unsigned CNT_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_stb_i,
  input  logic eol_stb_i,
  input  logic eof_stb_i,
  output logic lock_o
);
  logic [CNT_W-1:0] px_q, wid_q, hgt_q, pw_q, ph_q;
  logic             cons_q, pv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q   <= '0;
      wid_q  <= '0;
      hgt_q  <= '0;
      pw_q   <= '0;
      ph_q   <= '0;
      cons_q <= 1'b1;
      pv_q   <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      if (pix_stb_i) px_q <= px_q + 1'b1;
      if (eol_stb_i) begin
        px_q  <= '0;
        hgt_q <= hgt_q + 1'b1;
        if (hgt_q == '0)         wid_q  <= px_q;
        else if (px_q != wid_q)  cons_q <= 1'b0;
      end
      if (eof_stb_i) begin
        lock_o <= cons_q && pv_q && (wid_q == pw_q) && (hgt_q == ph_q);
        pw_q   <= wid_q;
        ph_q   <= hgt_q;
        pv_q   <= cons_q;
        wid_q  <= '0;
        hgt_q  <= '0;
        cons_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_sync_dec.sv
module vid_sync_dec
  import vid_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              lock_o,
  output logic              err_o
);
  logic [DATA_W-1:0] tap;
  code_t             code;
  logic              pix_stb, eol_stb, eof_stb;

  vid_trs_detect #(.DATA_W(DATA_W)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .tap_o (tap),
    .code_o(code)
  );

  vid_line_track #(.DATA_W(DATA_W)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tap_i    (tap),
    .code_i   (code),
    .pix_o    (pix_o),
    .de_o     (de_o),
    .hs_o     (hs_o),
    .vs_o     (vs_o),
    .err_o    (err_o),
    .pix_stb_o(pix_stb),
    .eol_stb_o(eol_stb),
    .eof_stb_o(eof_stb)
  );

  vid_frame_mon #(.CNT_W(CNT_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_stb_i(pix_stb),
    .eol_stb_i(eol_stb),
    .eof_stb_i(eof_stb),
    .lock_o   (lock_o)
  );
endmodule

// File: rtl/vid_sync_chk.sv
module vid_sync_chk
  import vid_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] pix_o,
  input logic              de_o,
  input logic              hs_o,
  input logic              vs_o,
  input logic              lock_o,
  input logic              err_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned LAT   = CODE_LEN + 1;

  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 age_q <= '0;
    else if (age_q != 3'(LAT))   age_q <= age_q + 1'b1;
  end

  logic rsv;
  always_comb begin
    rsv = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (pix_o[l*BYTE_W +: BYTE_W] == '0 || pix_o[l*BYTE_W +: BYTE_W] == '1) rsv = 1'b1;
    end
  end

  assert_pix_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'(LAT)) |-> (pix_o == $past(data_i, LAT)));

  assert_hs_not_de_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |-> !de_o);

  assert_hs_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |=> !hs_o);

  assert_hs_on_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |-> (pix_o == '1));

  assert_vs_on_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vs_o) |-> (pix_o == '1));

  assert_rsv_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && rsv) |-> err_o);

  assert_lock_at_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_o) |-> $rose(vs_o));
endmodule

bind vid_sync_dec vid_sync_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .data_i(data_i),
  .pix_o (pix_o),
  .de_o  (de_o),
  .hs_o  (hs_o),
  .vs_o  (vs_o),
  .lock_o(lock_o),
  .err_o (err_o)
);

// File: tb/tb_vid_sync_dec.sv
`timescale 1ns/1ps
module tb_vid_sync_dec;
  localparam int MAXW = 4096;
  localparam int LAT  = 5;  // words between drive index and checked index

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] data_i;
  logic [15:0] pix_o;
  logic        de_o, hs_o, vs_o, lock_o, err_o;

  always #5 clk = ~clk;

  vid_sync_dec dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .pix_o(pix_o),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .lock_o(lock_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0, widx = 0;
  bit done = 0;
  bit cur_vs = 0, cur_lock = 0;

  logic [15:0] e_pix [MAXW];
  bit e_de [MAXW], e_hs [MAXW], e_vs [MAXW], e_err [MAXW], e_lock [MAXW];

  // {width[7:0], lines[3:0], lock after frame}
  localparam logic [12:0] FRAMES [7] = '{
    {8'd8, 4'd4, 1'b0}, {8'd8, 4'd4, 1'b1}, {8'd8, 4'd4, 1'b1},
    {8'd6, 4'd4, 1'b0}, {8'd6, 4'd4, 1'b1},
    {8'd6, 4'd3, 1'b0}, {8'd6, 4'd3, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w, input bit de, input bit hs, input bit err);
    int k;
    @(negedge clk);
    if (widx >= LAT && widx - LAT < MAXW) begin
      k = widx - LAT;
      chk(pix_o == e_pix[k], "R2 pixel word", pix_o, e_pix[k]);
      chk(de_o == e_de[k], "R4 de (R3 code search)", de_o, e_de[k]);
      chk(hs_o == e_hs[k], "R5 hs", hs_o, e_hs[k]);
      chk(vs_o == e_vs[k], "R6 vs (R3 code search)", vs_o, e_vs[k]);
      chk(err_o == e_err[k], "R7 R8 err", err_o, e_err[k]);
      chk(lock_o == e_lock[k], "R9 R10 lock", lock_o, e_lock[k]);
    end
    rst_ni = 1'b1;
    if (widx < MAXW) begin
      e_pix[widx] = w; e_de[widx] = de; e_hs[widx] = hs;
      e_err[widx] = err; e_vs[widx] = cur_vs; e_lock[widx] = cur_lock;
    end
    data_i = w;
    widx++;
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) put(16'h8010, 0, 0, 0);
  endtask

  task automatic send_code(input logic [15:0] sts, input bit hs, input bit err);
    put(16'hFFFF, 0, hs, err);
    put(16'h0000, 0, 0, 0);
    put(16'h0000, 0, 0, 0);
    put(sts, 0, 0, 0);
  endtask

  task automatic active_line(input int w, input int y, input bit bad);
    logic [15:0] p;
    cur_vs = 0;
    send_code(16'h8080, 0, 0);
    for (int x = 0; x < w; x++) begin
      p = {8'h40 + 8'(x), 8'h20 + 8'(y)};
      if (bad && x == 2) put(16'h00FF, 1, 0, 1);  // R7 reserved bytes
      else               put(p, 1, 0, 0);
    end
    send_code(16'h9D9D, 1, 0);
    filler(3);
  endtask

  task automatic blank_line(input bit fend, input bit lk, input int extra);
    cur_vs = 1;
    if (fend) cur_lock = lk;
    send_code(16'hABAB, 0, 0);
    filler(2);
    if (extra == 1) send_code(16'h80AB, 0, 1);  // R8 unequal halves
    if (extra == 2) begin                         // R3 near-miss preamble
      put(16'hFFFE, 0, 0, 0); put(16'h0000, 0, 0, 0);
      put(16'h0000, 0, 0, 0); put(16'h8080, 0, 0, 0);
    end
    if (extra == 3) send_code(16'h8181, 0, 1);  // R8 illegal status
    filler(2);
    send_code(16'hB6B6, 1, 0);
    filler(3);
  endtask

  task automatic frame(input int w, input int h, input bit lk, input int short_y,
                       input bit bad, input int extra);
    for (int y = 0; y < h; y++) active_line((y == short_y) ? w - 1 : w, y, bad && y == 0);
    blank_line(1, lk, extra);
    blank_line(0, 0, 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    data_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(pix_o == 16'h0, "R1 reset pix", pix_o, 0);
    chk(de_o == 0, "R1 reset de", de_o, 0);
    chk(hs_o == 0, "R1 reset hs", hs_o, 0);
    chk(vs_o == 0, "R1 reset vs", vs_o, 0);
    chk(lock_o == 0, "R1 reset lock", lock_o, 0);
    chk(err_o == 0, "R1 reset err", err_o, 0);

    filler(3);
    for (int i = 0; i < 7; i++)
      frame(int'(FRAMES[i][12:5]), int'(FRAMES[i][4:1]), FRAMES[i][0], -1, 0, 0);

    // non-uniform frame: refused (R10), then not usable as reference
    frame(6, 3, 0, 1, 0, 3);
    frame(6, 3, 0, -1, 1, 1);
    frame(6, 3, 1, -1, 0, 2);
    filler(8);

    @(negedge clk);
    chk(lock_o == 1, "R9 lock held before reset", lock_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(lock_o == 0, "R1 async reset lock", lock_o, 0);
    chk(vs_o == 0, "R1 async reset vs", vs_o, 0);
    chk(pix_o == 16'h0, "R1 async reset pix", pix_o, 0);
    chk(de_o == 0 && hs_o == 0 && err_o == 0, "R1 async reset de hs err",
        {de_o, hs_o, err_o}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule